// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block gathers eight interrupt request lines, keeps a request register, an in-service register and a mask register, and raises one interrupt output to a processor. The lowest-numbered line wins. When the processor acknowledges with a one-cycle strobe, the block moves the winning request into service and returns an 8-bit vector. The vector is a programmed base plus the line number.

Software reaches the block through a byte-wide port. An address bit picks between a command port and a data port. A command byte starts a setup sequence, and the data bytes that follow fill the fields it announced. Later command bytes end service of a line or choose which register the status read returns.

A request that goes away before it is acknowledged still returns a vector: the one for the lowest-priority line. The in-service register is left untouched in that case, so software can recognise the event by reading in-service bit 7 as zero.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the request, in-service and mask registers read zero, `int_o` is low, status reads return the request register, and no setup sequence is open, so a data-port write goes straight to the mask.
- R2: A command write with bit 4 set opens setup and latches three flags from the same byte: bit 0 (a mode byte will follow), bit 1 (single mode, so the cascade byte is skipped) and bit 3 (level triggering). The next data writes are taken in this order: the vector base, then the cascade byte (only when bit 1 was clear), then the mode byte (only when bit 0 was set).
- R3: Data writes consumed by the setup sequence leave the mask unchanged. Once setup is done, data writes load the mask, and data-port reads (`a0`=1) return it.
- R4: A set mask bit keeps its line from raising `int_o`; a mask of 0xFF blocks every line. The line's request bit is still recorded.
- R5: Line 0 has the highest priority. `int_o` is high exactly when some unmasked request bit has a lower index than every set in-service bit.
- R6: One cycle after an `inta` strobe, `vec_vld` is high for one cycle and `vec_o` equals base + n for the winning line n. In-service bit n is set, and in edge mode request bit n is cleared.
- R7: A command write with bits 4:3 = 01 and bit 1 set picks the status source: bit 0 = 0 gives the request register, 1 gives the in-service register (0x0A and 0x0B). When bit 1 is clear, the current choice is kept.
- R8: A command write with bits 4:3 = 00 and bits 7:5 = 001 (for example 0x20) clears the lowest-indexed set in-service bit. Any other value with bits 4:3 = 00 leaves the in-service register unchanged.
- R9: When mode byte bit 1 was set during setup, an acknowledge does not set any in-service bit.
- R10: In edge mode, a rising line sets its request bit, and the bit clears if the line falls before acknowledge. A line held high after acknowledge does not request again.
- R11: In level mode, request bits follow the input lines one cycle later, and acknowledge does not clear them.
- R12: An acknowledge with no winning request returns base + 7 and leaves the in-service register unchanged.
- R13: While a line is in service, a lower-priority request keeps `int_o` low and a higher-priority request raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| a0 | input | 1 | Port select: 0 = command/status, 1 = data/mask |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Read byte: the mask when `a0`=1, otherwise the selected status register |
| irq_in | input | 8 | Request lines, synchronous to `clk` |
| int_o | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-cycle acknowledge strobe |
| vec_o | output | 8 | Vector of the last acknowledge |
| vec_vld | output | 1 | High for the one cycle in which `vec_o` is new |

## Verification
The assertions assume that `irq_in` is already synchronous to `clk`, that `wr_en` and `inta` are single-cycle strobes, and that an end-of-service command never lands in the same cycle as an acknowledge. The bench drives every input on the falling edge, keeps each strobe to one cycle and issues commands and acknowledges in separate tasks, so these conditions always hold. Request lines change only between host operations, which keeps the scoreboard's expected vectors tied to a single winning line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Setup sequencer position: which data byte is expected next
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_e;

    // Command byte decode positions
    localparam int START_BIT   = 4;
    localparam int STAT_BIT    = 3;
    localparam int HASMODE_BIT = 0;
    localparam int SINGLE_BIT  = 1;
    localparam int LEVEL_BIT   = 3;
    localparam int SELACT_BIT  = 1;
    localparam int SELSRC_BIT  = 0;
    localparam int AUTOEND_BIT = 1;
    localparam logic [2:0] EOI_CODE = 3'b001;

endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
    import irqc_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             a0,
    input  logic [7:0]       wdata,
    output logic [N_IRQ-1:0] mask,
    output logic [7:0]       base,
    output logic             level,
    output logic             aeoi,
    output logic             sel_isr,
    output logic             eoi_cmd
);

    typedef struct packed {
        seq_e             seq;
        logic             need_mode;
        logic             single;
        logic             level;
        logic             aeoi;
        logic             sel_isr;
        logic [7:0]       base;
        logic [N_IRQ-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic cmd_wr, dat_wr;

    always_comb begin
        cfg_d   = cfg_q;
        cmd_wr  = wr_en & ~a0;
        dat_wr  = wr_en & a0;
        eoi_cmd = 1'b0;

        if (cmd_wr) begin
            if (wdata[START_BIT]) begin
                cfg_d.seq       = SEQ_BASE;
                cfg_d.need_mode = wdata[HASMODE_BIT];
                cfg_d.single    = wdata[SINGLE_BIT];
                cfg_d.level     = wdata[LEVEL_BIT];
                cfg_d.aeoi      = 1'b0;
            end else if (wdata[STAT_BIT]) begin
                if (wdata[SELACT_BIT])
                    cfg_d.sel_isr = wdata[SELSRC_BIT];
            end else begin
                eoi_cmd = (wdata[7:5] == EOI_CODE);
            end
        end

        if (dat_wr) begin
            unique case (cfg_q.seq)
                SEQ_IDLE: cfg_d.mask = wdata[N_IRQ-1:0];
                SEQ_BASE: begin
                    cfg_d.base = wdata;
                    if (!cfg_q.single)
                        cfg_d.seq = SEQ_CASC;
                    else if (cfg_q.need_mode)
                        cfg_d.seq = SEQ_MODE;
                    else
                        cfg_d.seq = SEQ_IDLE;
                end
                SEQ_CASC: cfg_d.seq = cfg_q.need_mode ? SEQ_MODE : SEQ_IDLE;
                SEQ_MODE: begin
                    cfg_d.aeoi = wdata[AUTOEND_BIT];
                    cfg_d.seq  = SEQ_IDLE;
                end
                default: cfg_d.seq = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.seq       <= SEQ_IDLE;
            cfg_q.need_mode <= 1'b0;
            cfg_q.single    <= 1'b0;
            cfg_q.level     <= 1'b0;
            cfg_q.aeoi      <= 1'b0;
            cfg_q.sel_isr   <= 1'b0;
            cfg_q.base      <= '0;
            cfg_q.mask      <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask    = cfg_q.mask;
    assign base    = cfg_q.base;
    assign level   = cfg_q.level;
    assign aeoi    = cfg_q.aeoi;
    assign sel_isr = cfg_q.sel_isr;

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.seq != SEQ_IDLE) |=> $stable(cfg_q.mask));

    // R2
    single_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && !cmd_wr && cfg_q.seq == SEQ_BASE && cfg_q.single) |=> (cfg_q.seq != SEQ_CASC));

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic [N_IRQ-1:0] mask,
    input  logic [7:0]       base,
    input  logic             level,
    input  logic             aeoi,
    input  logic             eoi_cmd,
    input  logic             inta,
    output logic [N_IRQ-1:0] irr,
    output logic [N_IRQ-1:0] isr,
    output logic             int_o,
    output logic [7:0]       vec,
    output logic             vec_vld
);

    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
    localparam logic [7:0] LAST_LINE = 8'(N_IRQ - 1);

    typedef struct packed {
        logic [N_IRQ-1:0] irr;
        logic [N_IRQ-1:0] isr;
        logic [N_IRQ-1:0] prev;
        logic [7:0]       vec;
        logic             vld;
    } arb_t;

    arb_t arb_d, arb_q;

    logic [N_IRQ-1:0] pend, rise, eoi_clr, ack_set, win_hot;
    logic [IDX_W-1:0] p_idx, s_idx;
    logic             p_any, s_any, win;

    // lowest-index search over pending and in-service sets
    always_comb begin
        p_idx = '0;
        s_idx = '0;
        p_any = 1'b0;
        s_any = 1'b0;
        pend  = arb_q.irr & ~mask;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (pend[i]) begin
                p_idx = IDX_W'(i);
                p_any = 1'b1;
            end
            if (arb_q.isr[i]) begin
                s_idx = IDX_W'(i);
                s_any = 1'b1;
            end
        end
        win = p_any && (!s_any || (p_idx < s_idx));
    end

    always_comb begin
        arb_d   = arb_q;
        rise    = irq_in & ~arb_q.prev;
        win_hot = '0;
        win_hot[p_idx] = 1'b1;
        eoi_clr = '0;
        if (eoi_cmd && s_any)
            eoi_clr[s_idx] = 1'b1;
        ack_set = '0;

        arb_d.prev = irq_in;
        if (level)
            arb_d.irr = irq_in;
        else
            arb_d.irr = (arb_q.irr | rise) & irq_in;

        arb_d.vld = inta;
        if (inta) begin
            if (win) begin
                arb_d.vec = base + 8'(p_idx);
                if (!level)
                    arb_d.irr = arb_d.irr & ~win_hot;
                if (!aeoi)
                    ack_set = win_hot;
            end else begin
                arb_d.vec = base + LAST_LINE;
            end
        end
        arb_d.isr = (arb_q.isr & ~eoi_clr) | ack_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_q.irr  <= '0;
            arb_q.isr  <= '0;
            arb_q.prev <= '0;
            arb_q.vec  <= '0;
            arb_q.vld  <= 1'b0;
        end else begin
            arb_q <= arb_d;
        end
    end

    assign irr     = arb_q.irr;
    assign isr     = arb_q.isr;
    assign int_o   = win;
    assign vec     = arb_q.vec;
    assign vec_vld = arb_q.vld;

    // R4
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ((arb_q.irr & ~mask) != '0));

    // R6
    ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && win && !aeoi && !eoi_cmd) |=> ($countones(arb_q.isr) == $countones($past(arb_q.isr)) + 1));

    // R12
    spur_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !win && !eoi_cmd) |=> (arb_q.isr == $past(arb_q.isr)));

    // R8
    eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_cmd && !inta && (arb_q.isr != '0)) |=> ($countones(arb_q.isr) == $countones($past(arb_q.isr)) - 1));

    // R9
    auto_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && aeoi) |=> ((arb_q.isr & ~$past(arb_q.isr)) == '0));

endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 #(
    parameter int N_IRQ = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             a0,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [N_IRQ-1:0] irq_in,
    output logic             int_o,
    input  logic             inta,
    output logic [7:0]       vec_o,
    output logic             vec_vld
);

    logic [N_IRQ-1:0] mask, irr, isr;
    logic [7:0]       base;
    logic             level, aeoi, sel_isr, eoi_cmd;

    irqc_cfg #(.N_IRQ(N_IRQ)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .a0      (a0),
        .wdata   (wdata),
        .mask    (mask),
        .base    (base),
        .level   (level),
        .aeoi    (aeoi),
        .sel_isr (sel_isr),
        .eoi_cmd (eoi_cmd)
    );

    irqc_arb #(.N_IRQ(N_IRQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .mask    (mask),
        .base    (base),
        .level   (level),
        .aeoi    (aeoi),
        .eoi_cmd (eoi_cmd),
        .inta    (inta),
        .irr     (irr),
        .isr     (isr),
        .int_o   (int_o),
        .vec     (vec_o),
        .vec_vld (vec_vld)
    );

    always_comb begin
        if (a0)
            rdata = 8'(mask);
        else if (sel_isr)
            rdata = 8'(isr);
        else
            rdata = 8'(irr);
    end

    // R6
    vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |=> !vec_vld || $past(inta, 1));

endmodule

// File: tb/tb_irq_ctrl8.sv
module tb_irq_ctrl8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       a0 = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] irq_in = '0;
    logic       int_o;
    logic       inta = 1'b0;
    logic [7:0] vec_o;
    logic       vec_vld;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    irq_ctrl8 dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .a0(a0), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .int_o(int_o), .inta(inta),
        .vec_o(vec_o), .vec_vld(vec_vld)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        a0 = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        @(negedge clk);
        a0 = sel;
        #1 v = rdata;
    endtask

    // driver: strobe acknowledge and post the expected vector
    task automatic ack(input logic [7:0] exp);
        @(negedge clk);
        inta = 1'b1;
        exp_q.push_back(exp);
        @(negedge clk);
        inta = 1'b0;
    endtask

    // monitor: compare each produced vector against the scoreboard
    always @(negedge clk) begin
        if (rst_n && vec_vld) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R6: got vector 0x%02h expected none", vec_o);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                if (vec_o !== e) begin
                    n_bad++;
                    $display("FAIL R6/R12: got vector 0x%02h expected 0x%02h", vec_o, e);
                end
            end
        end
    end

    logic done = 1'b0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(1'b0, v); check("R1 irr", v, 8'h00);
        rd(1'b1, v); check("R1 mask", v, 8'h00);
        check("R1 int", {7'b0, int_o}, 8'h00);
        wr(1'b1, 8'h5A);
        rd(1'b1, v); check("R1 idle mask write", v, 8'h5A);

        // R2 R3 full sequence: edge, cascade, mode byte
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h04);
        wr(1'b1, 8'h01);
        rd(1'b1, v); check("R3 mask kept", v, 8'h5A);
        wr(1'b1, 8'h00);
        rd(1'b1, v); check("R3 mask load", v, 8'h00);

        // R5 R6 R7 R10 single edge request
        irq_in = 8'h08; tick();
        check("R5 int", {7'b0, int_o}, 8'h01);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); check("R7 irr sel", v, 8'h08);
        ack(8'h23);
        rd(1'b0, v); check("R10 irr cleared by ack", v, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); check("R6 isr set", v, 8'h08);
        check("R10 no retrigger", {7'b0, int_o}, 8'h00);

        // R13 nesting
        irq_in = 8'h28; tick();
        check("R13 lower blocked", {7'b0, int_o}, 8'h00);
        irq_in = 8'h2A; tick();
        check("R13 higher passes", {7'b0, int_o}, 8'h01);
        ack(8'h21);
        rd(1'b0, v); check("R13 nested isr", v, 8'h0A);
        wr(1'b0, 8'h20);
        rd(1'b0, v); check("R8 eoi top", v, 8'h08);
        check("R13 still blocked", {7'b0, int_o}, 8'h00);
        wr(1'b0, 8'h20);
        check("R5 pending wins", {7'b0, int_o}, 8'h01);
        ack(8'h25);
        wr(1'b0, 8'h40);
        rd(1'b0, v); check("R8 non-eoi ignored", v, 8'h20);
        wr(1'b0, 8'h20);
        rd(1'b0, v); check("R8 eoi clears", v, 8'h00);

        // R4 masking
        irq_in = 8'h00; tick();
        wr(1'b1, 8'hFF);
        irq_in = 8'h04; tick();
        check("R4 masked", {7'b0, int_o}, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); check("R4 irr recorded", v, 8'h04);
        wr(1'b1, 8'hFB);
        check("R4 unmasked", {7'b0, int_o}, 8'h01);
        ack(8'h22);
        wr(1'b0, 8'h20);

        // R10 R12 spurious
        irq_in = 8'h00; tick();
        irq_in = 8'h40; tick();
        wr(1'b1, 8'h00);
        check("R10 raised", {7'b0, int_o}, 8'h01);
        irq_in = 8'h00; tick();
        check("R10 dropped", {7'b0, int_o}, 8'h00);
        ack(8'h27);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); check("R12 isr unchanged", v, 8'h00);

        // R7 selection kept when bit 1 clear
        wr(1'b1, 8'hFF);
        irq_in = 8'h01; tick(); tick();
        wr(1'b0, 8'h08);
        rd(1'b0, v); check("R7 kept isr", v, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); check("R7 irr sel", v, 8'h01);
        irq_in = 8'h00; tick();

        // R2 R9 R11 single, level, auto end
        wr(1'b0, 8'h1B);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h03);
        rd(1'b1, v); check("R2 single skips cascade", v, 8'hFF);
        wr(1'b1, 8'h00);
        rd(1'b1, v); check("R2 sequence done", v, 8'h00);
        irq_in = 8'h10; tick();
        check("R11 level int", {7'b0, int_o}, 8'h01);
        ack(8'h44);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); check("R9 isr stays clear", v, 8'h00);
        wr(1'b0, 8'h0A);
        rd(1'b0, v); check("R11 irr held", v, 8'h10);
        irq_in = 8'h00; tick();
        rd(1'b0, v); check("R11 irr follows", v, 8'h00);
        check("R11 int low", {7'b0, int_o}, 8'h00);

        repeat (3) tick();
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R6: got %0d pending vectors expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule